// File: doc/BRIEF.md
# Streaming Sample Packet Framer

The framer turns a valid/ready stream of measurement tuples (X, Y, R, θ) into a byte stream of fixed-length packets. Each packet opens with a 32-bit header word and continues with a payload of 128, 256, 512 or 1024 bytes. The payload carries either one, two or four fields per tuple, as 32-bit floating-point words or as 16-bit integers. Tuples follow one another without gaps.

A packet begins when a tuple is offered while the framer is idle. In that cycle the framer captures the configuration inputs and the overload and error flags. It then forms the header from them and from a modulo-256 packet sequence number. The captured configuration governs the whole packet, so later changes on the configuration pins take effect only at the next packet. Payload bytes are taken straight from the presented tuple. The input handshake completes on the last byte of each tuple, which lets the output backpressure reach the producer without a buffer.

If the producer flags a tuple as the last of its stream before the packet is full, the framer raises a one-cycle truncation pulse. It then fills out the packet with zero bytes, so every packet keeps its declared length. Network encapsulation and checksum computation are left to later stages. Only the checksum-enabled flag travels in the header.

Top module: `sample_packet_framer`

## Requirements
- R1: Every packet starts with four header bytes sent most-significant byte first. The header word is status[31:24], rate code zero-extended in [23:16], length code zero-extended in [15:12], content code zero-extended in [11:8] and sequence number in [7:0]. `out_sop` is high on the first header byte only.
- R2: Status bit 24 is the overload flag and bit 25 the error flag. Bit 28 is set when little-endian payload is selected. Bit 29 is set when checksumming is enabled. Status bits 26, 27, 30 and 31 are zero.
- R3: The length code sets the payload that follows the header: 0 gives 1024 bytes, 1 gives 512, 2 gives 256 and 3 gives 128. `out_eop` is high on the last payload byte only, and the framer returns to idle after it.
- R4: The sequence number is 0 in the first packet after reset. It rises by one per packet and wraps from 255 to 0.
- R5: Content codes 0, 1, 2 and 3 select the field sets X, XY, Rθ and XYRθ as 4-byte floats. Codes 4 to 7 select the same sets as 2-byte integers, each integer being the low 16 bits of its input field.
- R6: Within a tuple, the selected fields go out in X, Y, R, θ order. Successive tuples follow in the order accepted.
- R7: With big-endian selected, each field is sent most-significant byte first. With little-endian selected, the bytes of each field are reversed at the field's own width (4 bytes for floats, 2 for integers).
- R8: Overload and error are sampled once, in the cycle a packet starts. Later changes do not alter that packet's header.
- R9: Content, length, rate, endianness and checksum flag are captured at packet start. Changes during a packet do not alter its header, length, field selection or byte order.
- R10: When a tuple marked by `in_last` is accepted and the packet is not yet full, `trunc_err` pulses for one cycle. The rest of the payload is zero bytes, and the packet keeps its full length.
- R11: While `out_valid` is high and `out_ready` low, the output byte is held. `in_ready` is high only in a cycle where the last byte of a tuple is transferred. After reset, `out_valid`, `in_ready` and `trunc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tuple offered |
| in_ready | output | 1 | Tuple consumed this cycle |
| in_last | input | 1 | Tuple is the last of the stream |
| in_x | input | 32 | X field |
| in_y | input | 32 | Y field |
| in_r | input | 32 | R field |
| in_t | input | 32 | θ field |
| cfg_content | input | 3 | Field set and format code |
| cfg_len | input | 2 | Payload length code |
| cfg_rate | input | 5 | Rate code, passed to the header |
| cfg_little | input | 1 | 1 selects little-endian fields |
| cfg_cksum | input | 1 | Checksum-enabled flag for the header |
| st_overload | input | 1 | Overload condition |
| st_error | input | 1 | Error condition |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |
| trunc_err | output | 1 | Stream ended inside a packet |

## Verification
A wrong byte or field index shows up at once in the payload bytes of the packet in progress: bytes appear swapped, shifted or taken from the wrong field. A wrong payload counter moves `out_eop` and shows within one packet. A sequence number or captured configuration that is off shows in the header of the next packet. The bench therefore compares every byte of every packet, including the start and end markers, across formats, lengths, backpressure, truncation and a full wrap of the sequence number.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int FIELD_W     = 32;
    localparam int NUM_FIELDS  = 4;
    localparam int SEQ_W       = 8;
    localparam int MAX_PAYLOAD = 1024;
    localparam int PAY_W       = $clog2(MAX_PAYLOAD) + 1;
    localparam int FLT_BYTES   = FIELD_W / 8;
    localparam int INT_BYTES   = FLT_BYTES / 2;
    localparam int SB_W        = $clog2(NUM_FIELDS * FLT_BYTES) + 1;
    localparam int BIDX_W      = SB_W - 1;

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA, ST_PAD} fsm_t;

    typedef struct packed {
        logic [2:0] content;
        logic [1:0] len;
        logic [4:0] rate;
        logic       little;
        logic       cksum;
    } cfg_t;

    // index 0 = X, 1 = Y, 2 = R, 3 = theta
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] sample_t;

    function automatic logic [PAY_W-1:0] payload_bytes(input logic [1:0] len);
        logic [PAY_W-1:0] full;
        full = PAY_W'(MAX_PAYLOAD);
        return full >> len;
    endfunction

    function automatic logic [SB_W-1:0] sample_bytes(input logic [2:0] content);
        logic [SB_W-1:0] nf;
        logic [SB_W-1:0] fw;
        case (content[1:0])
            2'd0:    nf = SB_W'(1);
            2'd1,
            2'd2:    nf = SB_W'(2);
            default: nf = SB_W'(NUM_FIELDS);
        endcase
        fw = content[2] ? SB_W'(INT_BYTES) : SB_W'(FLT_BYTES);
        return SB_W'(nf * fw);
    endfunction

    function automatic logic [31:0] build_header(input cfg_t c, input logic ovl,
                                                 input logic err,
                                                 input logic [SEQ_W-1:0] seq);
        logic [7:0] status;
        status = {2'b00, c.cksum, c.little, 2'b00, err, ovl};
        return {status, 3'b000, c.rate, 2'b00, c.len, 1'b0, c.content, seq};
    endfunction
endpackage

// File: rtl/framer_header.sv
module framer_header
    import framer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             done,
    input  cfg_t             cfg_i,
    input  logic             ovl_i,
    input  logic             err_i,
    output cfg_t             cfg_q,
    output logic [31:0]      hdr_q,
    output logic [SEQ_W-1:0] seq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            hdr_q <= '0;
            seq_q <= '0;
        end else begin
            if (start) begin
                cfg_q <= cfg_i;
                hdr_q <= build_header(cfg_i, ovl_i, err_i, seq_q);
            end
            if (done) begin
                seq_q <= seq_q + SEQ_W'(1);
            end
        end
    end
endmodule

// File: rtl/framer_bytesel.sv
module framer_bytesel
    import framer_pkg::*;
(
    input  cfg_t              cfg,
    input  sample_t           smp,
    input  logic [BIDX_W-1:0] idx,
    output logic [7:0]        byte_o
);
    localparam int POS_W = $clog2(FLT_BYTES);

    logic [BIDX_W-1:0] fidx;
    logic [POS_W-1:0]  b;
    logic [POS_W-1:0]  pos;
    logic [1:0]        fsel;
    logic [FIELD_W-1:0] word;

    always_comb begin
        if (cfg.content[2]) begin
            fidx = idx >> $clog2(INT_BYTES);
            b    = POS_W'(idx[$clog2(INT_BYTES)-1:0]);
            pos  = cfg.little ? b : POS_W'(INT_BYTES - 1) - b;
        end else begin
            fidx = idx >> $clog2(FLT_BYTES);
            b    = idx[POS_W-1:0];
            pos  = cfg.little ? b : POS_W'(FLT_BYTES - 1) - b;
        end
        // field set R,theta starts at field 2; all other sets start at X
        fsel   = (cfg.content[1:0] == 2'd2) ? fidx[1:0] + 2'd2 : fidx[1:0];
        word   = smp[fsel];
        byte_o = word[{pos, 3'b000} +: 8];
    end
endmodule

// File: rtl/sample_packet_framer.sv
module sample_packet_framer
    import framer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_last,
    input  logic [FIELD_W-1:0] in_x,
    input  logic [FIELD_W-1:0] in_y,
    input  logic [FIELD_W-1:0] in_r,
    input  logic [FIELD_W-1:0] in_t,
    input  logic [2:0]         cfg_content,
    input  logic [1:0]         cfg_len,
    input  logic [4:0]         cfg_rate,
    input  logic               cfg_little,
    input  logic               cfg_cksum,
    input  logic               st_overload,
    input  logic               st_error,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic               trunc_err
);
    fsm_t              state_q;
    logic [1:0]        hidx_q;
    logic [PAY_W-1:0]  pay_q;
    logic [BIDX_W-1:0] bidx_q;
    cfg_t              cfg_in;
    cfg_t              cfg_q;
    logic [31:0]       hdr_q;
    logic [SEQ_W-1:0]  seq_q;
    sample_t           smp;
    logic [7:0]        sel_byte;
    logic              start;
    logic              fire;
    logic              pay_last;
    logic              samp_last;
    logic              done;

    assign cfg_in = '{content: cfg_content, len: cfg_len, rate: cfg_rate,
                      little: cfg_little, cksum: cfg_cksum};
    assign smp    = {in_t, in_r, in_y, in_x};

    assign start     = (state_q == ST_IDLE) && in_valid;
    assign pay_last  = pay_q == payload_bytes(cfg_q.len) - PAY_W'(1);
    assign samp_last = {1'b0, bidx_q} == sample_bytes(cfg_q.content) - SB_W'(1);
    assign fire      = out_valid && out_ready;
    assign done      = fire && out_eop;

    framer_header u_header (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .done  (done),
        .cfg_i (cfg_in),
        .ovl_i (st_overload),
        .err_i (st_error),
        .cfg_q (cfg_q),
        .hdr_q (hdr_q),
        .seq_q (seq_q)
    );

    framer_bytesel u_bytesel (
        .cfg    (cfg_q),
        .smp    (smp),
        .idx    (bidx_q),
        .byte_o (sel_byte)
    );

    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        in_ready  = 1'b0;
        case (state_q)
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_q[{~hidx_q, 3'b000} +: 8];
                out_sop   = hidx_q == 2'd0;
            end
            ST_DATA: begin
                out_valid = in_valid;
                out_data  = sel_byte;
                out_eop   = pay_last;
                in_ready  = out_ready && samp_last;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_eop   = pay_last;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            hidx_q    <= '0;
            pay_q     <= '0;
            bidx_q    <= '0;
            trunc_err <= 1'b0;
        end else begin
            trunc_err <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    hidx_q <= '0;
                    pay_q  <= '0;
                    bidx_q <= '0;
                    if (start) state_q <= ST_HDR;
                end
                ST_HDR: if (fire) begin
                    hidx_q <= hidx_q + 2'd1;
                    if (hidx_q == 2'd3) state_q <= ST_DATA;
                end
                ST_DATA: if (fire) begin
                    pay_q  <= pay_q + PAY_W'(1);
                    bidx_q <= samp_last ? '0 : bidx_q + BIDX_W'(1);
                    if (pay_last) begin
                        state_q <= ST_IDLE;
                    end else if (samp_last && in_last) begin
                        state_q   <= ST_PAD;
                        trunc_err <= 1'b1;
                    end
                end
                ST_PAD: if (fire) begin
                    pay_q <= pay_q + PAY_W'(1);
                    if (pay_last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/framer_checker.sv
module framer_checker
    import framer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_sop,
    input logic             out_eop,
    input logic             in_ready,
    input logic             trunc_err,
    input fsm_t             state_q,
    input cfg_t             cfg_q,
    input logic [SEQ_W-1:0] seq_q
);
    // R1: start marker covers a single byte
    a_r1_sop_single: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_sop |=> !out_sop);

    // R3: framer is idle right after the end marker is taken
    a_r3_eop_to_idle: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_eop |=> state_q == ST_IDLE);

    // R4: sequence number only ever steps by one
    a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(seq_q) |-> seq_q == $past(seq_q) + SEQ_W'(1));

    // R9: captured configuration frozen inside a packet
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) |-> $stable(cfg_q));

    // R10: truncation pulse only while padding
    a_r10_trunc_pads: assert property (@(posedge clk) disable iff (rst)
        trunc_err |-> state_q == ST_PAD);

    // R11: input consumed only together with an output transfer
    a_r11_ready_on_xfer: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_valid && out_ready);

    // R11: header and pad bytes held under backpressure
    a_r11_hold_byte: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && state_q != ST_DATA |=> out_valid && $stable(out_data));
endmodule

bind sample_packet_framer framer_checker i_framer_checker (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .in_ready  (in_ready),
    .trunc_err (trunc_err),
    .state_q   (state_q),
    .cfg_q     (cfg_q),
    .seq_q     (seq_q)
);

// File: tb/test_sample_packet_framer.sv
module test_sample_packet_framer;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_last;
    logic [31:0] in_x, in_y, in_r, in_t;
    logic [2:0]  cfg_content;
    logic [1:0]  cfg_len;
    logic [4:0]  cfg_rate;
    logic        cfg_little, cfg_cksum, st_overload, st_error;
    logic        out_valid, out_ready, out_sop, out_eop, trunc_err;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    sample_packet_framer i_sample_packet_framer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_x(in_x), .in_y(in_y), .in_r(in_r), .in_t(in_t),
        .cfg_content(cfg_content), .cfg_len(cfg_len), .cfg_rate(cfg_rate),
        .cfg_little(cfg_little), .cfg_cksum(cfg_cksum),
        .st_overload(st_overload), .st_error(st_error),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .trunc_err(trunc_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int pkt_no = 0;

    logic [7:0] cap [0:1100];
    int ncap, nsop, sop_idx, neop, eop_idx, trunc_seen, rdy_viol;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fval(input int k, input int f);
        return {8'(8'h10 + f), 8'(k), 8'(8'hC0 + f), 8'(k * 3 + 1)};
    endfunction

    function automatic logic [7:0] exp_pay(input logic [2:0] c, input bit little,
                                           input int pos, input int nsent);
        int fw, nf, sb, s, r, fi, b, fid, bp;
        logic [31:0] w;
        fw = c[2] ? 2 : 4;
        case (c[1:0])
            2'd0: nf = 1;
            2'd3: nf = 4;
            default: nf = 2;
        endcase
        sb = nf * fw; s = pos / sb; r = pos % sb; fi = r / fw; b = r % fw;
        fid = (c[1:0] == 2'd2) ? fi + 2 : fi;
        bp = little ? b : fw - 1 - b;
        if (s >= nsent) return 8'h00;
        w = fval(s, fid);
        return w[8*bp +: 8];
    endfunction

    function automatic logic [31:0] exp_hdr(input logic [2:0] c, input logic [1:0] len,
                                            input logic [4:0] rate, input bit little,
                                            input bit ck, input bit ovl, input bit err,
                                            input int cnt);
        return {2'b00, ck, little, 2'b00, err, ovl, 3'b000, rate, 2'b00, len, 1'b0, c, 8'(cnt)};
    endfunction

    task automatic drive_sample(input int k);
        in_x = fval(k, 0); in_y = fval(k, 1); in_r = fval(k, 2); in_t = fval(k, 3);
    endtask

    // Runs one packet; trunc_at < 0 means a full packet.
    task automatic run_packet(input logic [2:0] c, input logic [1:0] len, input logic [4:0] rate,
                              input bit little, input bit ck, input bit ovl, input bit err,
                              input int trunc_at, input bit bp, input bit mid, output int nsent);
        int sb, total, k, cyc;
        bit done, xin;
        sb = (c[1:0] == 2'd0 ? 1 : (c[1:0] == 2'd3 ? 4 : 2)) * (c[2] ? 2 : 4);
        total = (1024 >> len) / sb;
        nsent = (trunc_at < 0) ? total : trunc_at;
        cfg_content = c; cfg_len = len; cfg_rate = rate; cfg_little = little; cfg_cksum = ck;
        st_overload = ovl; st_error = err;
        ncap = 0; nsop = 0; sop_idx = -1; neop = 0; eop_idx = -1; trunc_seen = 0; rdy_viol = 0;
        k = 0; cyc = 0; done = 0;
        drive_sample(0);
        in_last = (trunc_at >= 0) && (nsent == 1);
        in_valid = 1'b1;
        while (!done && cyc < 6000) begin
            @(negedge clk);
            if (out_valid && out_ready) begin
                if (out_sop) begin nsop++; if (sop_idx < 0) sop_idx = ncap; end
                if (out_eop) begin neop++; eop_idx = ncap; done = 1; end
                if (ncap <= 1100) cap[ncap] = out_data;
                ncap++;
            end
            if (in_ready && !out_ready) rdy_viol++;
            if (trunc_err) trunc_seen++;
            xin = in_valid && in_ready;
            @(posedge clk);
            #1;
            cyc++;
            if (xin) begin
                k++;
                if (k == 1 && mid) begin
                    cfg_content = ~c; cfg_len = ~len; cfg_rate = ~rate;
                    cfg_little = ~little; cfg_cksum = ~ck;
                    st_overload = ~ovl; st_error = ~err;
                end
                if (k < nsent) begin
                    drive_sample(k);
                    in_last = (trunc_at >= 0) && (k == nsent - 1);
                end else begin
                    in_valid = 1'b0; in_last = 1'b0;
                end
            end
            if (bp) out_ready = (cyc % 3) != 2;
        end
        out_ready = 1'b1; in_valid = 1'b0; in_last = 1'b0;
        pkt_no++;
    endtask

    task automatic check_packet(input string tag, input logic [2:0] c, input logic [1:0] len,
                                input logic [4:0] rate, input bit little, input bit ck,
                                input bit ovl, input bit err, input int nsent);
        logic [31:0] hdr, eh;
        int plen, bad, first;
        logic [7:0] a, e;
        plen = 1024 >> len;
        hdr = {cap[0], cap[1], cap[2], cap[3]};
        eh = exp_hdr(c, len, rate, little, ck, ovl, err, (pkt_no - 1) % 256);
        check(hdr == eh, {tag, " R1 R2 R4 header"}, hdr, eh);
        check(nsop == 1 && sop_idx == 0, {tag, " R1 sop position"}, sop_idx, 0);
        check(neop == 1 && eop_idx == plen + 3 && ncap == plen + 4,
              {tag, " R3 eop/length"}, ncap, plen + 4);
        bad = 0; first = -1; a = 0; e = 0;
        for (int i = 0; i < plen; i++) begin
            if (cap[i + 4] !== exp_pay(c, little, i, nsent)) begin
                if (first < 0) begin first = i; a = cap[i + 4]; e = exp_pay(c, little, i, nsent); end
                bad++;
            end
        end
        check(bad == 0, {tag, " R5 R6 R7 payload byte"}, a, e);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 0; in_last = 0; out_ready = 1;
        cfg_content = 0; cfg_len = 0; cfg_rate = 0; cfg_little = 0; cfg_cksum = 0;
        st_overload = 0; st_error = 0; drive_sample(0);
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !in_ready && !trunc_err, "R11 reset outputs", {out_valid, in_ready, trunc_err}, 0);
    endtask

    task automatic t_float_all_big;
        int n;
        run_packet(3'd3, 2'd3, 5'd7, 0, 1, 1, 0, -1, 0, 0, n);
        check_packet("float XYRT big", 3'd3, 2'd3, 5'd7, 0, 1, 1, 0, n);
    endtask

    task automatic t_int_x_little;
        int n;
        run_packet(3'd4, 2'd3, 5'd31, 1, 0, 0, 1, -1, 0, 0, n);
        check_packet("int X little", 3'd4, 2'd3, 5'd31, 1, 0, 0, 1, n);
    endtask

    task automatic t_float_rt_little;
        int n;
        run_packet(3'd2, 2'd2, 5'd0, 1, 1, 1, 1, -1, 0, 0, n);
        check_packet("float RT little", 3'd2, 2'd2, 5'd0, 1, 1, 1, 1, n);
    endtask

    task automatic t_int_xy_long;
        int n;
        run_packet(3'd5, 2'd0, 5'd12, 0, 0, 0, 0, -1, 0, 0, n);
        check_packet("int XY 1024", 3'd5, 2'd0, 5'd12, 0, 0, 0, 0, n);
        run_packet(3'd1, 2'd1, 5'd3, 0, 0, 0, 0, -1, 0, 0, n);
        check_packet("float XY 512", 3'd1, 2'd1, 5'd3, 0, 0, 0, 0, n);
    endtask

    task automatic t_mid_change;
        int n;
        run_packet(3'd6, 2'd3, 5'd9, 0, 0, 1, 0, -1, 0, 1, n);
        check_packet("mid change R8 R9", 3'd6, 2'd3, 5'd9, 0, 0, 1, 0, n);
    endtask

    task automatic t_truncate;
        int n;
        run_packet(3'd3, 2'd3, 5'd1, 1, 0, 0, 0, 3, 0, 0, n);
        check_packet("truncated R10", 3'd3, 2'd3, 5'd1, 1, 0, 0, 0, n);
        check(trunc_seen == 1, "R10 trunc pulse count", trunc_seen, 1);
    endtask

    task automatic t_backpressure;
        int n;
        run_packet(3'd7, 2'd3, 5'd4, 1, 1, 0, 0, -1, 1, 0, n);
        check_packet("backpressure R11", 3'd7, 2'd3, 5'd4, 1, 1, 0, 0, n);
        check(rdy_viol == 0, "R11 in_ready without transfer", rdy_viol, 0);
        check(trunc_seen == 0, "R10 no pulse on full packet", trunc_seen, 0);
    endtask

    task automatic t_seq_wrap;
        int n;
        logic [7:0] got;
        while (pkt_no < 258) begin
            run_packet(3'd7, 2'd3, 5'd2, 0, 0, 0, 0, -1, 0, 0, n);
            got = cap[3];
            check(got == 8'((pkt_no - 1) % 256), "R4 sequence number", got, (pkt_no - 1) % 256);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_float_all_big();
        t_int_x_little();
        t_float_rt_little();
        t_int_xy_long();
        t_mid_change();
        t_truncate();
        t_backpressure();
        t_seq_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule